// File: doc/BRIEF.md
# 8-bit ALU with flag update

This block is the arithmetic and logic unit of a small 8-bit microcontroller core. The core's decoder presents an operation code, a destination operand, a source operand and the current program-flags byte. The ALU returns the result byte, a strobe saying whether the result is to be written back, and the new flags byte. For the two 16-bit increment and decrement operations, the operand pair and the result pair are split over two bytes.

Every operation has its own rule for each flag: updated, forced, kept or left alone. The test and compare operations set flags but write no result. Decimal adjust uses the decimal-adjust and half-carry flags left by the preceding add or subtract to correct a byte to packed BCD. Flags that an operation leaves undefined keep their incoming value. The outputs are registered by default, so they appear one clock after the inputs. A parameter can make them combinational.

Top module: `alu8_core`

## Requirements
- R1: Flags byte layout: bit 7 carry (C), 6 zero (Z), 5 sign (S), 4 overflow (V), 3 decimal-adjust (D), 2 half-carry (H). Bits 1:0 are user flags that leave the ALU unchanged for every operation.
- R2: ADD (code 0) and ADC (code 1) write d+s (ADC adds the incoming C). C is the carry out of bit 7 and H the carry out of bit 3. V flags signed overflow. Z and S follow the result, and D is cleared.
- R3: SUB (2) and SBC (3) write d-s (SBC also subtracts the incoming C). C is set on a borrow from bit 7 and H on a borrow from bit 3. V flags signed overflow. Z and S follow the result, and D is set.
- R4: AND (4), OR (5) and XOR (6) write the bitwise result. They update Z and S, clear V, and keep C, D and H.
- R5: TM (7) evaluates d AND s and TCM (8) evaluates (NOT d) AND s. Both update Z and S, clear V and keep C, D and H. CP (9) evaluates d-s and updates only C, Z, S and V. None of the three writes a result.
- R6: ROL (10) moves bit 7 into bit 0 and into C. ROLC (11) moves C into bit 0 and bit 7 into C. ROR (12) moves bit 0 into bit 7 and into C. RORC (13) moves C into bit 7 and bit 0 into C. All four update Z and S, and set V when the sign bit changed.
- R7: SRA (14) keeps bit 7, shifts right and moves bit 0 into C. It updates Z and S and clears V.
- R8: SWAP (15) exchanges the two nibbles and updates Z and S. C and V keep their incoming values.
- R9: INC (16) and DEC (17) write d+1 and d-1. They update Z and S, set V on signed overflow (7F to 80, 80 to 7F), and keep C, D and H.
- R10: INCW (18) and DECW (19) treat {d,s} as one 16-bit value with d as the high byte, and return it plus or minus one on {res_hi,res}. Z covers all 16 bits, S is bit 15 and V is 16-bit signed overflow. C, D and H are kept. res_hi is zero for every other operation.
- R11: COM (20) writes NOT d, updates Z and S and clears V. CLR (21) writes zero and leaves every flag unchanged.
- R12: CCF (22) inverts C, SCF (23) sets C and RCF (24) clears C. None of them writes a result or changes any other flag.
- R13: DA (25) with D=0 adds 06 when H=1 or the low nibble exceeds 9, and adds 60 (setting C) when C=1 or the byte exceeds 99. With D=1 it subtracts 06 when H=1 and 60 when C=1, and C keeps its incoming value. It updates Z and S and keeps V.
- R14: Outputs settle one clock after the inputs, and reset drives them all to zero. Codes 26 to 31 write nothing and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 5 | Operation code |
| opd_d | input | 8 | Destination operand (high byte for word operations) |
| opd_s | input | 8 | Source operand (low byte for word operations) |
| flags_in | input | 8 | Current flags byte |
| res | output | 8 | Result byte (low byte for word operations) |
| res_hi | output | 8 | High result byte of word operations |
| res_we | output | 1 | Result is to be written back |
| flags_out | output | 8 | Updated flags byte |

## Verification
The add and subtract paths are tried with operand pairs chosen to separate the carry out of bit 3 from the carry out of bit 7. Pairs at 7F/80 separate signed overflow from unsigned carry, and pairs that wrap to zero check Z. The rotates run on patterns with bit 0 and bit 7 set unequally and with both values of incoming C, which tells circular rotation apart from rotation through carry. The flags byte is preset with its kept bits set opposite to what an update would produce, so keep and overwrite can be told apart. A long sweep of pseudo-random operands over every code, including the unused ones, compares each output against an independent model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = 2 * BYTE_W;
   localparam int unsigned NIB_W  = BYTE_W / 2;
   localparam int unsigned OP_W   = 5;

   // flag bit positions inside the flags byte
   localparam int unsigned FL_C = 7;
   localparam int unsigned FL_Z = 6;
   localparam int unsigned FL_S = 5;
   localparam int unsigned FL_V = 4;
   localparam int unsigned FL_D = 3;
   localparam int unsigned FL_H = 2;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
      OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_TM   = 5'd7,
      OP_TCM  = 5'd8,  OP_CP   = 5'd9,  OP_ROL  = 5'd10, OP_ROLC = 5'd11,
      OP_ROR  = 5'd12, OP_RORC = 5'd13, OP_SRA  = 5'd14, OP_SWAP = 5'd15,
      OP_INC  = 5'd16, OP_DEC  = 5'd17, OP_INCW = 5'd18, OP_DECW = 5'd19,
      OP_COM  = 5'd20, OP_CLR  = 5'd21, OP_CCF  = 5'd22, OP_SCF  = 5'd23,
      OP_RCF  = 5'd24, OP_DA   = 5'd25
   } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
   import alu8_pkg::*;
#(
   parameter int unsigned W  = BYTE_W,
   parameter int unsigned HB = NIB_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         c_out,
   output logic         h_out,
   output logic         v_out
);
   logic [W-1:0] b_eff;
   logic         cin_eff;
   logic [W:0]   full;
   logic [HB:0]  half;

   always_comb begin
      b_eff   = sub ? ~b : b;
      cin_eff = sub ? ~cin : cin;
      full    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
      half    = {1'b0, a[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, cin_eff};
      sum     = full[W-1:0];
      c_out   = sub ? ~full[W] : full[W];
      h_out   = sub ? ~half[HB] : half[HB];
      v_out   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
   end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
   import alu8_pkg::*;
(
   input  alu_op_e           op,
   input  logic [BYTE_W-1:0] d,
   input  logic              c_in,
   output logic [BYTE_W-1:0] r,
   output logic              c_out
);
   localparam int unsigned MSB = BYTE_W - 1;

   always_comb begin
      r     = d;
      c_out = c_in;
      case (op)
         OP_ROL:  begin r = {d[MSB-1:0], d[MSB]}; c_out = d[MSB]; end
         OP_ROLC: begin r = {d[MSB-1:0], c_in};   c_out = d[MSB]; end
         OP_ROR:  begin r = {d[0], d[MSB:1]};     c_out = d[0];   end
         OP_RORC: begin r = {c_in, d[MSB:1]};     c_out = d[0];   end
         OP_SRA:  begin r = {d[MSB], d[MSB:1]};   c_out = d[0];   end
         OP_SWAP: r = {d[NIB_W-1:0], d[MSB:NIB_W]};
         default: ;
      endcase
   end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
   import alu8_pkg::*;
(
   input  logic [BYTE_W-1:0] d,
   input  logic              c_in,
   input  logic              h_in,
   input  logic              sub,
   output logic [BYTE_W-1:0] r,
   output logic              c_out
);
   logic              fix_lo;
   logic              fix_hi;
   logic [BYTE_W-1:0] adj;

   always_comb begin
      fix_lo = h_in || (!sub && (d[NIB_W-1:0] > 4'd9));
      fix_hi = c_in || (!sub && (d > 8'h99));
      adj    = {(fix_hi ? 4'h6 : 4'h0), (fix_lo ? 4'h6 : 4'h0)};
      r      = sub ? (d - adj) : (d + adj);
      c_out  = fix_hi;
   end
endmodule

// File: rtl/alu8_word.sv
module alu8_word
   import alu8_pkg::*;
#(
   parameter int unsigned W = WORD_W
) (
   input  logic [W-1:0] w_in,
   input  logic         dec,
   output logic [W-1:0] w_out,
   output logic         v_out
);
   always_comb begin
      w_out = dec ? (w_in - {{(W-1){1'b0}}, 1'b1}) : (w_in + {{(W-1){1'b0}}, 1'b1});
      v_out = dec ? (w_in[W-1] & ~w_out[W-1]) : (~w_in[W-1] & w_out[W-1]);
   end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter bit          REG_OUT  = 1'b1,
   parameter bit          WORD_OPS = 1'b1,
   parameter int unsigned FLAG_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [OP_W-1:0]     op_sel,
   input  logic [BYTE_W-1:0]   opd_d,
   input  logic [BYTE_W-1:0]   opd_s,
   input  logic [FLAG_W-1:0]   flags_in,
   output logic [BYTE_W-1:0]   res,
   output logic [BYTE_W-1:0]   res_hi,
   output logic                res_we,
   output logic [FLAG_W-1:0]   flags_out
);
   localparam int unsigned MSB = BYTE_W - 1;

   if (FLAG_W != BYTE_W) begin : g_bad_flag_w
      $error("alu8_core: FLAG_W must equal the byte width");
   end
   if (FL_H < 2) begin : g_bad_layout
      $error("alu8_core: flag layout leaves no room for user flags");
   end

   alu_op_e op_e;
   assign op_e = alu_op_e'(op_sel);

   // add / subtract / compare
   logic              as_sub, as_cin, as_c, as_h, as_v;
   logic [BYTE_W-1:0] as_sum;
   assign as_sub = (op_e == OP_SUB) || (op_e == OP_SBC) || (op_e == OP_CP);
   assign as_cin = ((op_e == OP_ADC) || (op_e == OP_SBC)) ? flags_in[FL_C] : 1'b0;

   alu8_addsub #(.W(BYTE_W), .HB(NIB_W)) u_addsub (
      .a(opd_d), .b(opd_s), .cin(as_cin), .sub(as_sub),
      .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
   );

   // rotates, shift, swap
   logic [BYTE_W-1:0] sh_r;
   logic              sh_c;
   alu8_shift u_shift (
      .op(op_e), .d(opd_d), .c_in(flags_in[FL_C]), .r(sh_r), .c_out(sh_c)
   );

   // decimal adjust
   logic [BYTE_W-1:0] da_r;
   logic              da_c;
   alu8_bcd u_bcd (
      .d(opd_d), .c_in(flags_in[FL_C]), .h_in(flags_in[FL_H]),
      .sub(flags_in[FL_D]), .r(da_r), .c_out(da_c)
   );

   // 16-bit increment / decrement
   logic [WORD_W-1:0] wd_r;
   logic              wd_v;
   if (WORD_OPS) begin : g_word
      alu8_word #(.W(WORD_W)) u_word (
         .w_in({opd_d, opd_s}), .dec(op_e == OP_DECW), .w_out(wd_r), .v_out(wd_v)
      );
   end else begin : g_no_word
      assign wd_r = '0;
      assign wd_v = 1'b0;
   end

   logic [BYTE_W-1:0] r_nx, rh_nx, inc_r, dec_r;
   logic              we_nx;
   logic [FLAG_W-1:0] f_nx;

   assign inc_r = opd_d + 8'd1;
   assign dec_r = opd_d - 8'd1;

   always_comb begin
      f_nx  = flags_in;
      r_nx  = '0;
      rh_nx = '0;
      we_nx = 1'b0;
      case (op_e)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
            r_nx = as_sum; we_nx = 1'b1;
            f_nx[FL_C] = as_c; f_nx[FL_H] = as_h; f_nx[FL_V] = as_v;
            f_nx[FL_D] = as_sub;
         end
         OP_CP: begin
            r_nx = as_sum; f_nx[FL_C] = as_c; f_nx[FL_V] = as_v;
         end
         OP_AND:  begin r_nx = opd_d & opd_s;  we_nx = 1'b1; f_nx[FL_V] = 1'b0; end
         OP_OR:   begin r_nx = opd_d | opd_s;  we_nx = 1'b1; f_nx[FL_V] = 1'b0; end
         OP_XOR:  begin r_nx = opd_d ^ opd_s;  we_nx = 1'b1; f_nx[FL_V] = 1'b0; end
         OP_TM:   begin r_nx = opd_d & opd_s;  f_nx[FL_V] = 1'b0; end
         OP_TCM:  begin r_nx = ~opd_d & opd_s; f_nx[FL_V] = 1'b0; end
         OP_ROL, OP_ROLC, OP_ROR, OP_RORC: begin
            r_nx = sh_r; we_nx = 1'b1; f_nx[FL_C] = sh_c;
            f_nx[FL_V] = sh_r[MSB] ^ opd_d[MSB];
         end
         OP_SRA:  begin r_nx = sh_r; we_nx = 1'b1; f_nx[FL_C] = sh_c; f_nx[FL_V] = 1'b0; end
         OP_SWAP: begin r_nx = sh_r; we_nx = 1'b1; end
         OP_INC:  begin r_nx = inc_r; we_nx = 1'b1; f_nx[FL_V] = inc_r[MSB] & ~opd_d[MSB]; end
         OP_DEC:  begin r_nx = dec_r; we_nx = 1'b1; f_nx[FL_V] = ~dec_r[MSB] & opd_d[MSB]; end
         OP_INCW, OP_DECW: begin
            if (WORD_OPS) begin
               r_nx = wd_r[BYTE_W-1:0]; rh_nx = wd_r[WORD_W-1:BYTE_W]; we_nx = 1'b1;
               f_nx[FL_V] = wd_v;
            end
         end
         OP_COM:  begin r_nx = ~opd_d; we_nx = 1'b1; f_nx[FL_V] = 1'b0; end
         OP_CLR:  begin r_nx = '0; we_nx = 1'b1; end
         OP_CCF:  f_nx[FL_C] = ~flags_in[FL_C];
         OP_SCF:  f_nx[FL_C] = 1'b1;
         OP_RCF:  f_nx[FL_C] = 1'b0;
         OP_DA:   begin r_nx = da_r; we_nx = 1'b1; f_nx[FL_C] = da_c; end
         default: ;
      endcase
      // zero and sign follow the produced value for every operation that owns them
      case (op_e)
         OP_INCW, OP_DECW: begin
            if (WORD_OPS) begin
               f_nx[FL_Z] = (wd_r == '0);
               f_nx[FL_S] = wd_r[WORD_W-1];
            end
         end
         OP_CLR, OP_CCF, OP_SCF, OP_RCF: ;
         default: begin
            if (op_sel <= 5'(OP_DA)) begin
               f_nx[FL_Z] = (r_nx == '0);
               f_nx[FL_S] = r_nx[MSB];
            end
         end
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res       <= '0;
            res_hi    <= '0;
            res_we    <= 1'b0;
            flags_out <= '0;
         end else begin
            res       <= r_nx;
            res_hi    <= rh_nx;
            res_we    <= we_nx;
            flags_out <= f_nx;
         end
      end
   end else begin : g_comb
      assign res       = r_nx;
      assign res_hi    = rh_nx;
      assign res_we    = we_nx;
      assign flags_out = f_nx;
   end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
   import alu8_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OP_W-1:0]   op_sel,
   input logic [BYTE_W-1:0] opd_d,
   input logic [BYTE_W-1:0] flags_in,
   input logic [BYTE_W-1:0] res,
   input logic              res_we,
   input logic [BYTE_W-1:0] flags_out
);
   logic              primed;
   logic [OP_W-1:0]   op_c;
   logic [BYTE_W-1:0] d_c;
   logic [BYTE_W-1:0] fi_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
         op_c <= op_sel;
         d_c  <= opd_d;
         fi_c <= flags_in;
      end
   end else begin : g_now
      assign op_c = op_sel;
      assign d_c  = opd_d;
      assign fi_c = flags_in;
   end

   AST_USER_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> flags_out[1:0] == fi_c[1:0]); // R1

   AST_ADD_CLEARS_D: assert property (@(posedge clk) disable iff (!rst_n)
      primed && (op_c == OP_ADD || op_c == OP_ADC) |-> !flags_out[FL_D] && res_we); // R2

   AST_SUB_SETS_D: assert property (@(posedge clk) disable iff (!rst_n)
      primed && (op_c == OP_SUB || op_c == OP_SBC) |-> flags_out[FL_D] && res_we); // R3

   AST_LOGIC_KEEPS_CDH: assert property (@(posedge clk) disable iff (!rst_n)
      primed && (op_c == OP_AND || op_c == OP_OR || op_c == OP_XOR) |->
      !flags_out[FL_V] && flags_out[FL_C] == fi_c[FL_C] &&
      flags_out[FL_D] == fi_c[FL_D] && flags_out[FL_H] == fi_c[FL_H]); // R4

   AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      primed && (op_c == OP_TM || op_c == OP_TCM || op_c == OP_CP) |-> !res_we); // R5

   AST_SWAP_NIBBLES: assert property (@(posedge clk) disable iff (!rst_n)
      primed && op_c == OP_SWAP |-> res == {d_c[3:0], d_c[7:4]} &&
      flags_out[FL_C] == fi_c[FL_C] && flags_out[FL_V] == fi_c[FL_V]); // R8

   AST_CLR_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      primed && op_c == OP_CLR |-> res == '0 && res_we && flags_out == fi_c); // R11

   AST_CARRY_OPS_ONLY_C: assert property (@(posedge clk) disable iff (!rst_n)
      primed && (op_c == OP_CCF || op_c == OP_SCF || op_c == OP_RCF) |->
      !res_we && flags_out[6:0] == fi_c[6:0]); // R12

   AST_UNUSED_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      primed && op_c > OP_W'(OP_DA) |-> !res_we && flags_out == fi_c); // R14
endmodule

bind alu8_core alu8_core_chk #(.REG_OUT(REG_OUT)) chk_i (
   .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opd_d(opd_d),
   .flags_in(flags_in), .res(res), .res_we(res_we), .flags_out(flags_out)
);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_sel = 5'd26;
   logic [7:0] opd_d = '0, opd_s = '0, flags_in = '0;
   logic [7:0] res, res_hi, flags_out;
   logic       res_we;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   alu8_core dut_i (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opd_d(opd_d), .opd_s(opd_s),
      .flags_in(flags_in), .res(res), .res_hi(res_hi), .res_we(res_we),
      .flags_out(flags_out)
   );

   typedef struct {
      logic [7:0] r;
      logic [7:0] rh;
      logic       we;
      logic       word;
      logic [7:0] f;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   // independent model written from the requirements (flag bits: 7 C,6 Z,5 S,4 V,3 D,2 H)
   function automatic exp_t ref_calc(input int op, input logic [7:0] d, input logic [7:0] s,
                                     input logic [7:0] f);
      exp_t e;
      int   t, cb, lo;
      logic [7:0]  r;
      logic [15:0] w;
      logic        zs;
      e.f = f; e.r = '0; e.rh = '0; e.we = 1'b0; e.word = 1'b0; e.tag = "";
      r = '0; zs = 1'b1;
      case (op)
         0, 1: begin
            cb = (op == 1) ? int'(f[7]) : 0;
            t  = int'(d) + int'(s) + cb;
            lo = int'(d[3:0]) + int'(s[3:0]) + cb;
            r  = t[7:0]; e.we = 1'b1;
            e.f[7] = (t > 255); e.f[2] = (lo > 15); e.f[3] = 1'b0;
            e.f[4] = (d[7] == s[7]) && (r[7] != d[7]);
         end
         2, 3, 9: begin
            cb = (op == 3) ? int'(f[7]) : 0;
            t  = int'(d) - int'(s) - cb;
            lo = int'(d[3:0]) - int'(s[3:0]) - cb;
            r  = t[7:0];
            e.f[7] = (t < 0);
            e.f[4] = (d[7] != s[7]) && (r[7] != d[7]);
            if (op != 9) begin e.we = 1'b1; e.f[2] = (lo < 0); e.f[3] = 1'b1; end
         end
         4: begin r = d & s; e.we = 1'b1; e.f[4] = 1'b0; end
         5: begin r = d | s; e.we = 1'b1; e.f[4] = 1'b0; end
         6: begin r = d ^ s; e.we = 1'b1; e.f[4] = 1'b0; end
         7: begin r = d & s;  e.f[4] = 1'b0; end
         8: begin r = ~d & s; e.f[4] = 1'b0; end
         10: begin r = {d[6:0], d[7]}; e.f[7] = d[7]; e.we = 1'b1; e.f[4] = r[7] ^ d[7]; end
         11: begin r = {d[6:0], f[7]}; e.f[7] = d[7]; e.we = 1'b1; e.f[4] = r[7] ^ d[7]; end
         12: begin r = {d[0], d[7:1]}; e.f[7] = d[0]; e.we = 1'b1; e.f[4] = r[7] ^ d[7]; end
         13: begin r = {f[7], d[7:1]}; e.f[7] = d[0]; e.we = 1'b1; e.f[4] = r[7] ^ d[7]; end
         14: begin r = {d[7], d[7:1]}; e.f[7] = d[0]; e.we = 1'b1; e.f[4] = 1'b0; end
         15: begin r = {d[3:0], d[7:4]}; e.we = 1'b1; end
         16: begin r = d + 8'd1; e.we = 1'b1; e.f[4] = (d == 8'h7F); end
         17: begin r = d - 8'd1; e.we = 1'b1; e.f[4] = (d == 8'h80); end
         18, 19: begin
            w = (op == 18) ? ({d, s} + 16'd1) : ({d, s} - 16'd1);
            e.we = 1'b1; e.word = 1'b1; r = w[7:0]; e.rh = w[15:8]; zs = 1'b0;
            e.f[6] = (w == 16'h0000); e.f[5] = w[15];
            e.f[4] = (op == 18) ? ({d, s} == 16'h7FFF) : ({d, s} == 16'h8000);
         end
         20: begin r = ~d; e.we = 1'b1; e.f[4] = 1'b0; end
         21: begin r = 8'h00; e.we = 1'b1; zs = 1'b0; end
         22: begin e.f[7] = ~f[7]; zs = 1'b0; end
         23: begin e.f[7] = 1'b1; zs = 1'b0; end
         24: begin e.f[7] = 1'b0; zs = 1'b0; end
         25: begin
            e.we = 1'b1;
            if (!f[3]) begin
               t = int'(d);
               if (f[2] || d[3:0] > 4'd9) t = t + 6;
               if (f[7] || d > 8'h99) begin t = t + 96; e.f[7] = 1'b1; end
               else e.f[7] = 1'b0;
            end else begin
               t = int'(d) - (f[2] ? 6 : 0) - (f[7] ? 96 : 0);
            end
            r = t[7:0];
         end
         default: zs = 1'b0;
      endcase
      if (zs) begin e.f[6] = (r == 8'h00); e.f[5] = r[7]; end
      e.r = r;
      return e;
   endfunction

   // driver: apply one operation and queue what must come out a clock later
   task automatic send(input int op, input logic [7:0] d, input logic [7:0] s,
                       input logic [7:0] f, input string tag);
      exp_t e;
      @(negedge clk);
      op_sel = 5'(op); opd_d = d; opd_s = s; flags_in = f;
      e = ref_calc(op, d, s, f);
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: outputs are registered, compare just after the edge that loads them
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (res_we !== e.we || flags_out !== e.f ||
                (e.we && res !== e.r) || (e.word && res_hi !== e.rh) ||
                (!e.word && res_hi !== 8'h00)) begin
               errors++;
               $display("FAIL %s: got res=%h hi=%h we=%b fl=%b, expected res=%h hi=%h we=%b fl=%b",
                        e.tag, res, res_hi, res_we, flags_out, e.r, e.rh, e.we, e.f);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] lf;
      repeat (3) @(posedge clk);
      #2;
      checks++;
      if (res !== 8'h00 || res_hi !== 8'h00 || res_we !== 1'b0 || flags_out !== 8'h00) begin
         errors++;
         $display("FAIL R14 reset: got res=%h hi=%h we=%b fl=%h, expected all zero",
                  res, res_hi, res_we, flags_out);
      end
      @(negedge clk);
      rst_n = 1'b1;

      send(0, 8'h7F, 8'h01, 8'h0B, "R2 add overflow+half, D cleared, R1 user bits");
      send(0, 8'hFF, 8'h01, 8'h00, "R2 add carry to zero");
      send(1, 8'h10, 8'h0F, 8'h80, "R2 adc with carry in");
      send(2, 8'h10, 8'h01, 8'h03, "R3 sub half borrow");
      send(2, 8'h80, 8'h01, 8'h00, "R3 sub signed overflow");
      send(3, 8'h00, 8'h00, 8'h80, "R3 sbc borrow through zero");
      send(4, 8'hF0, 8'h3C, 8'h8C, "R4 and keeps C D H");
      send(5, 8'h00, 8'h00, 8'h1C, "R4 or zero clears V");
      send(6, 8'hAA, 8'h55, 8'h80, "R4 xor");
      send(7, 8'h0F, 8'hF0, 8'h9F, "R5 tm no write");
      send(8, 8'h0F, 8'hF0, 8'h1C, "R5 tcm no write");
      send(9, 8'h05, 8'h07, 8'h0C, "R5 cp borrow, D H kept");
      send(10, 8'h81, 8'h00, 8'h00, "R6 rol circular");
      send(11, 8'h81, 8'h00, 8'h00, "R6 rolc through carry C=0");
      send(11, 8'h40, 8'h00, 8'h80, "R6 rolc through carry C=1");
      send(12, 8'h01, 8'h00, 8'h00, "R6 ror circular");
      send(13, 8'h02, 8'h00, 8'h80, "R6 rorc through carry");
      send(14, 8'h81, 8'h00, 8'h10, "R7 sra keeps sign");
      send(15, 8'h3C, 8'h00, 8'h90, "R8 swap keeps C V");
      send(15, 8'h00, 8'h00, 8'h00, "R8 swap zero");
      send(16, 8'h7F, 8'h00, 8'h8C, "R9 inc overflow keeps C");
      send(17, 8'h80, 8'h00, 8'h00, "R9 dec overflow");
      send(16, 8'hFF, 8'h00, 8'h80, "R9 inc wrap to zero");
      send(18, 8'h7F, 8'hFF, 8'h80, "R10 incw overflow");
      send(18, 8'hFF, 8'hFF, 8'h00, "R10 incw wrap to zero");
      send(19, 8'h00, 8'h00, 8'h0C, "R10 decw underflow");
      send(19, 8'h01, 8'h00, 8'h00, "R10 decw across byte");
      send(20, 8'h5A, 8'h00, 8'h10, "R11 com");
      send(21, 8'h77, 8'h00, 8'hFF, "R11 clr keeps flags");
      send(22, 8'h00, 8'h00, 8'h81, "R12 ccf");
      send(23, 8'h00, 8'h00, 8'h02, "R12 scf");
      send(24, 8'h00, 8'h00, 8'hFE, "R12 rcf");
      send(25, 8'h3C, 8'h00, 8'h00, "R13 da after add low fix");
      send(25, 8'h9A, 8'h00, 8'h10, "R13 da after add both fix");
      send(25, 8'h2D, 8'h00, 8'h0C, "R13 da after sub H");
      send(25, 8'hC8, 8'h00, 8'h88, "R13 da after sub C kept");
      send(26, 8'h12, 8'h34, 8'h5A, "R14 unused code");
      send(31, 8'hFF, 8'hFF, 8'hA5, "R14 unused code top");

      lf = 8'h5D;
      for (int i = 0; i < 640; i++) begin
         logic [7:0] a, b;
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         a  = lf ^ 8'(i * 37);
         b  = 8'(i * 91) ^ {lf[3:0], lf[7:4]};
         send(i % 32, a, b, lf ^ 8'(i), "R1 R14 sweep");
      end

      @(negedge clk);
      op_sel = 5'd26;
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule